// File: doc/BRIEF.md
# Serial Port Buffer Status Unit

This block keeps the status word of a synchronous serial port's transmit and receive buffers and presents it as one 16-bit read value to the processor bus. It watches the buffer fill levels and the shifter and bus strobes. From them it derives three live level flags and four sticky error flags: overflow and underflow for each direction. All flags are registered, so the status word shows the conditions sampled at the previous clock edge.

Sticky flags are cleared by a status write with a 1 in the flag's position, or when the matching direction's enable goes from 1 to 0. Each direction has a two-state tracker: DIR_OFF and DIR_ON. The ENABLE transition moves it from DIR_OFF to DIR_ON when the enable is seen high. The DISABLE transition moves it from DIR_ON to DIR_OFF when the enable is seen low, and clears that direction's sticky flags in the same cycle. Receive underflow is detected whatever the receive enable is.

Top module: `sps_status_unit`

## Requirements
- R1: After reset the status word reads 0x0040: only bit 6, the transmit-hold-empty flag, is set.
- R2: Bit 0 (receive not empty) is 1 in the cycle after `rx_level` is non-zero, and 0 in the cycle after it is zero.
- R3: Bit 3 (transmit full) is 1 in the cycle after `tx_level` equals TX_DEPTH. Bit 6 (transmit hold empty) is 1 in the cycle after `tx_level` is zero.
- R4: Bit 2 (receive overflow) is set in the next cycle when `rx_word_done` is high while `rx_level` equals RX_DEPTH.
- R5: Bit 1 (receive underflow) is set in the next cycle when `rx_rd` is high while `rx_level` is zero, whether or not `rx_en` is high.
- R6: Bit 4 (transmit overflow) is set in the next cycle when `tx_wr` is high while `tx_level` equals TX_DEPTH.
- R7: Bit 5 (transmit underflow) is set in the next cycle when `tx_need` is high, `tx_en` is high and `tx_level` is zero. With `tx_en` low, `tx_need` does not set it.
- R8: A status write (`stat_we`) with a 1 in a sticky flag's bit clears that flag in the next cycle. A 0 in that bit leaves the flag unchanged.
- R9: When `rx_en` is seen low after being seen high, bits 1 and 2 clear. When `tx_en` falls in the same way, bits 4 and 5 clear.
- R10: If a set condition and a clear (write-one or disable) occur in the same cycle, the flag ends up set.
- R11: Writes to the live bits 0, 3 and 6 and to reserved bits 15..7 have no effect. Reserved bits always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive direction enable |
| tx_en | input | 1 | Transmit direction enable |
| rx_word_done | input | 1 | Receive shifter completed a word |
| rx_level | input | $clog2(RX_DEPTH+1) | Words held in the receive buffer |
| rx_rd | input | 1 | Processor read of receive data |
| tx_level | input | $clog2(TX_DEPTH+1) | Words held in the transmit buffer |
| tx_wr | input | 1 | Processor write of transmit data |
| tx_need | input | 1 | Transmit shifter requests a word |
| stat_we | input | 1 | Status register write strobe |
| stat_wdata | input | 16 | Status write data (write-one-to-clear) |
| stat_rdata | output | 16 | Status word |

## Verification
The bench keeps a behavioural model of the status word and compares all 16 bits on every clock. The stimulus covers these patterns:
- empty, partly filled and full buffer levels, which separate the live flags at their boundaries;
- strobes at the empty or full boundary and just off it, which show that each error is tied to the right level;
- a receive read with the port disabled, and a transmit request with transmit disabled, which separate the two directions' enable handling;
- one-bit and all-ones clearing writes, enable falls, and set-plus-clear collisions, which separate the clear paths from the set priority.

// File: rtl/sps_status_pkg.sv
package sps_status_pkg;
    localparam int STAT_W     = 16;
    localparam int B_RX_NE    = 0;
    localparam int B_RX_UVF   = 1;
    localparam int B_RX_OVF   = 2;
    localparam int B_TX_FULL  = 3;
    localparam int B_TX_OVF   = 4;
    localparam int B_TX_UVF   = 5;
    localparam int B_TX_HE    = 6;
    localparam int N_STICKY   = 4;

    typedef enum logic {
        DIR_OFF = 1'b0,
        DIR_ON  = 1'b1
    } dir_state_e;
endpackage

// File: rtl/sps_dir_fsm.sv
module sps_dir_fsm
    import sps_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic disable_clr
);
    dir_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DIR_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DIR_OFF: if (en)  state_d = DIR_ON;   // ENABLE
            DIR_ON:  if (!en) state_d = DIR_OFF;  // DISABLE
            default: state_d = DIR_OFF;
        endcase
    end

    always_comb begin
        disable_clr = (state_q == DIR_ON) && !en;
    end
endmodule

// File: rtl/sps_sticky.sv
module sps_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic w1c,
    input  logic dis_clr,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)              flag_q <= 1'b0;
        else if (set_ev)         flag_q <= 1'b1;
        else if (w1c || dis_clr) flag_q <= 1'b0;
    end
endmodule

// File: rtl/sps_status_unit.sv
module sps_status_unit
    import sps_status_pkg::*;
#(
    parameter int RX_DEPTH = 8,
    parameter int TX_DEPTH = 8,
    localparam int RX_LW = $clog2(RX_DEPTH + 1),
    localparam int TX_LW = $clog2(TX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              tx_en,
    input  logic              rx_word_done,
    input  logic [RX_LW-1:0]  rx_level,
    input  logic              rx_rd,
    input  logic [TX_LW-1:0]  tx_level,
    input  logic              tx_wr,
    input  logic              tx_need,
    input  logic              stat_we,
    input  logic [STAT_W-1:0] stat_wdata,
    output logic [STAT_W-1:0] stat_rdata
);
    localparam int STICKY_POS [N_STICKY] = '{B_RX_UVF, B_RX_OVF, B_TX_OVF, B_TX_UVF};

    logic rx_empty, rx_full, tx_empty, tx_full;
    logic rx_dis, tx_dis;
    logic rx_ne_q, tx_full_q, tx_he_q;
    logic [N_STICKY-1:0] set_v, dis_v, w1c_v, flag_v;

    assign rx_empty = (rx_level == RX_LW'(0));
    assign rx_full  = (rx_level == RX_LW'(RX_DEPTH));
    assign tx_empty = (tx_level == TX_LW'(0));
    assign tx_full  = (tx_level == TX_LW'(TX_DEPTH));

    sps_dir_fsm rx_fsm_i (.clk(clk), .rst_n(rst_n), .en(rx_en), .disable_clr(rx_dis));
    sps_dir_fsm tx_fsm_i (.clk(clk), .rst_n(rst_n), .en(tx_en), .disable_clr(tx_dis));

    // Set events, in the order of STICKY_POS
    assign set_v[0] = rx_rd && rx_empty;
    assign set_v[1] = rx_word_done && rx_full;
    assign set_v[2] = tx_wr && tx_full;
    assign set_v[3] = tx_need && tx_en && tx_empty;
    assign dis_v    = {tx_dis, tx_dis, rx_dis, rx_dis};

    genvar gi;
    generate
        for (gi = 0; gi < N_STICKY; gi++) begin : g_sticky
            assign w1c_v[gi] = stat_we && stat_wdata[STICKY_POS[gi]];
            sps_sticky flag_i (
                .clk(clk), .rst_n(rst_n), .set_ev(set_v[gi]),
                .w1c(w1c_v[gi]), .dis_clr(dis_v[gi]), .flag_q(flag_v[gi])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_ne_q   <= 1'b0;
            tx_full_q <= 1'b0;
            tx_he_q   <= 1'b1;
        end else begin
            rx_ne_q   <= !rx_empty;
            tx_full_q <= tx_full;
            tx_he_q   <= tx_empty;
        end
    end

    always_comb begin
        stat_rdata            = '0;
        stat_rdata[B_RX_NE]   = rx_ne_q;
        stat_rdata[B_TX_FULL] = tx_full_q;
        stat_rdata[B_TX_HE]   = tx_he_q;
        for (int k = 0; k < N_STICKY; k++) stat_rdata[STICKY_POS[k]] = flag_v[k];
    end
endmodule

// File: rtl/sps_status_chk.sv
module sps_status_chk #(
    parameter int RX_DEPTH = 8,
    parameter int TX_DEPTH = 8,
    localparam int RX_LW = $clog2(RX_DEPTH + 1),
    localparam int TX_LW = $clog2(TX_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_en,
    input logic             tx_en,
    input logic             rx_word_done,
    input logic [RX_LW-1:0] rx_level,
    input logic             rx_rd,
    input logic [TX_LW-1:0] tx_level,
    input logic             tx_wr,
    input logic             tx_need,
    input logic             stat_we,
    input logic [15:0]      stat_wdata,
    input logic [15:0]      stat_rdata
);
    // R2
    rx_ne_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level != 0) |=> stat_rdata[0]);
    // R3
    tx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level == TX_LW'(TX_DEPTH)) |=> stat_rdata[3]);
    // R4
    rx_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_word_done && rx_level == RX_LW'(RX_DEPTH)) |=> stat_rdata[2]);
    // R5
    rx_uvf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && rx_level == 0) |=> stat_rdata[1]);
    // R6
    tx_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_level == TX_LW'(TX_DEPTH)) |=> stat_rdata[4]);
    // R7
    tx_uvf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_need && tx_en && tx_level == 0) |=> stat_rdata[5]);
    // R8
    w1c_rx_uvf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && stat_wdata[1] && !(rx_rd && rx_level == 0)) |=> !stat_rdata[1]);
    // R9
    tx_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tx_en) && !(tx_wr && tx_level == TX_LW'(TX_DEPTH))) |=> !stat_rdata[4]);
endmodule

bind sps_status_unit sps_status_chk #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_en(tx_en),
    .rx_word_done(rx_word_done), .rx_level(rx_level), .rx_rd(rx_rd),
    .tx_level(tx_level), .tx_wr(tx_wr), .tx_need(tx_need),
    .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata)
);

// File: tb/sps_status_unit_tb.sv
module sps_status_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RXD = 8;
    localparam int TXD = 8;
    localparam int RLW = $clog2(RXD + 1);
    localparam int TLW = $clog2(TXD + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 0, tx_en = 0, rx_word_done = 0, rx_rd = 0, tx_wr = 0, tx_need = 0, stat_we = 0;
    logic [RLW-1:0] rx_level = '0;
    logic [TLW-1:0] tx_level = '0;
    logic [15:0] stat_wdata = '0;
    logic [15:0] stat_rdata;

    int checks = 0;
    int failures = 0;

    // reference model state
    bit m_rxne = 0, m_txfull = 0, m_txhe = 1;
    bit m_rov = 0, m_ruv = 0, m_tov = 0, m_tuv = 0;
    bit m_prx = 0, m_ptx = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sps_status_unit #(.RX_DEPTH(RXD), .TX_DEPTH(TXD)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_en(tx_en),
        .rx_word_done(rx_word_done), .rx_level(rx_level), .rx_rd(rx_rd),
        .tx_level(tx_level), .tx_wr(tx_wr), .tx_need(tx_need),
        .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata)
    );

    function automatic string req_of(int b);
        case (b)
            0: return "R2";
            1: return "R5";
            2: return "R4";
            3, 6: return "R3";
            4: return "R6";
            5: return "R7";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [15:0] expected();
        logic [15:0] e = '0;
        e[0] = m_rxne; e[1] = m_ruv; e[2] = m_rov; e[3] = m_txfull;
        e[4] = m_tov;  e[5] = m_tuv; e[6] = m_txhe;
        return e;
    endfunction

    task automatic compare(string tag);
        logic [15:0] e = expected();
        checks++;
        if (stat_rdata !== e) begin
            failures++;
            for (int b = 0; b < 16; b++)
                if (stat_rdata[b] !== e[b])
                    $display("FAIL %s bit%0d [%s] actual=%h expected=%h", req_of(b), b, tag, stat_rdata, e);
        end
    endtask

    task automatic model_step();
        bit rdis = m_prx && !rx_en;
        bit tdis = m_ptx && !tx_en;
        bit s_ruv = rx_rd && (rx_level == 0);
        bit s_rov = rx_word_done && (rx_level == RLW'(RXD));
        bit s_tov = tx_wr && (tx_level == TLW'(TXD));
        bit s_tuv = tx_need && tx_en && (tx_level == 0);
        m_ruv = s_ruv || (m_ruv && !(stat_we && stat_wdata[1]) && !rdis);
        m_rov = s_rov || (m_rov && !(stat_we && stat_wdata[2]) && !rdis);
        m_tov = s_tov || (m_tov && !(stat_we && stat_wdata[4]) && !tdis);
        m_tuv = s_tuv || (m_tuv && !(stat_we && stat_wdata[5]) && !tdis);
        m_rxne = (rx_level != 0);
        m_txfull = (tx_level == TLW'(TXD));
        m_txhe = (tx_level == 0);
        m_prx = rx_en;
        m_ptx = tx_en;
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
        rx_word_done = 0; rx_rd = 0; tx_wr = 0; tx_need = 0; stat_we = 0; stat_wdata = '0;
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset value
        compare("R1 reset");
        rst_n = 1;
        tick("R1 idle");
        rx_en = 1; tx_en = 1;
        tick("enable");
        // R2: live receive level
        rx_level = 3; tick("R2 partial");
        rx_level = 1; tick("R2 one");
        rx_level = 0; tick("R2 empty");
        // R3: transmit full and hold empty
        tx_level = TLW'(TXD - 1); tick("R3 near full");
        tx_level = TLW'(TXD); tick("R3 full");
        // R6: write while full, then write while not full
        tx_wr = 1; tick("R6 ovf");
        tx_level = TLW'(TXD - 1); tx_wr = 1; tick("R6 no ovf");
        // R4: word done while full, and just below full
        rx_level = RLW'(RXD - 1); rx_word_done = 1; tick("R4 below full");
        rx_level = RLW'(RXD); rx_word_done = 1; tick("R4 ovf");
        // R8: clear one sticky, the other stays
        stat_we = 1; stat_wdata = 16'h0004; tick("R8 clear rx ovf");
        stat_we = 1; stat_wdata = 16'h0010; tick("R8 clear tx ovf");
        // R5: read while empty with receive disabled
        rx_level = 0; rx_en = 0; tick("R5 disable");
        rx_rd = 1; tick("R5 uvf while off");
        rx_level = 2; rx_rd = 1; tick("R5 read non-empty");
        // R7: transmit need while disabled and enabled
        tx_level = 0; tx_en = 0; tick("R7 tx off");
        tx_need = 1; tick("R7 no set when off");
        tx_en = 1; tick("R7 tx on");
        tx_need = 1; tick("R7 uvf");
        tx_level = 2; tx_need = 1; tick("R7 not empty");
        // R10: set and write-one-to-clear together
        rx_level = 0; rx_rd = 1; stat_we = 1; stat_wdata = 16'hFFFF; tick("R10 set vs w1c");
        // R11: writes to live and reserved bits ignored
        rx_level = 4; tx_level = TLW'(TXD); tick("R11 prep");
        stat_we = 1; stat_wdata = 16'hFF49; tick("R11 live write");
        tick("R11 hold");
        // R9: disabling clears sticky flags of that direction
        tx_wr = 1; tick("R9 set tx ovf");
        rx_level = 0; rx_rd = 1; tick("R9 set rx uvf");
        tx_en = 0; tick("R9 tx disable");
        rx_en = 1; tick("R9 rx enable");
        rx_en = 0; tick("R9 rx disable");
        // R10: set during disable cycle
        tx_en = 1; tick("R10 tx on");
        tx_en = 0; tx_wr = 1; tick("R10 set vs disable");
        stat_we = 1; stat_wdata = 16'hFFFF; tick("R8 clear all");
        tick("final");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule